// File: doc/BRIEF.md
# Data Packet CRC-16 Serializer and Checker

The block turns one data packet into an unstuffed serial bit stream. A start pulse loads an 8-bit packet identifier and a payload byte count. The identifier goes out first, least significant bit first. The payload bytes follow, accepted one at a time through a valid/ready handshake and each shifted out least significant bit first. A 16-bit check value computed over the payload alone closes the packet. A downstream stage (bit stuffing, line coding) pulls one bit per cycle in which it raises `bit_adv`. It can hold the stream at any point, so it can insert its own bits between ours.

The same block holds an independent receive checker. The receive checker is fed the unstuffed bit stream of an incoming packet, identifier included, framed by a start pulse and an end pulse. One cycle after the end pulse it reports whether the check value matched. The packet identifier value itself is supplied by the caller. Choosing between the two data identifiers happens elsewhere.

Top module: `pkt_crc_serializer`

## Requirements
- R1: After `tx_start` with `tx_len` of 1023 or less, the first 8 bits out are `tx_pid`, bit 0 first, and these bits do not enter the check value.
- R2: Payload bytes go out in the order they were accepted, each byte bit 0 first, directly after the identifier.
- R3: The check value uses generator x^16+x^15+x^2+1 with the register preset to all ones, fed with payload bits only. Its ones-complement goes out after the payload, coefficient of x^15 first, for 16 bits.
- R4: With `tx_len` of 0 the packet is the 8 identifier bits followed by 16 zero bits.
- R5: `tx_start` with `tx_len` above 1023 raises `len_err` for exactly one cycle (the cycle after the start). No bit is presented and `tx_busy` stays low.
- R6: `in_ready` is low while identifier or check bits are being presented. It is high only in the payload phase when no byte is held.
- R7: While `out_valid` is high and `bit_adv` is low, `out_bit` and `out_valid` hold. Each cycle with both high consumes exactly one bit.
- R8: `out_last` is high exactly on the 16th check bit, and `tx_busy` is low in the cycle after that bit is consumed.
- R9: `tx_start` during a packet is ignored. The packet in flight continues unchanged.
- R10: `rx_done` is high for one cycle, in the cycle after `rx_end`. At that point `rx_crc_ok` is 1 when three things hold: the register, fed from all bits after the first 8, ends at 16'h800D; at least 24 bits arrived; and the bit count is a multiple of 8.
- R11: A single flipped bit in the payload or check field makes `rx_crc_ok` 0. A flipped bit in the first 8 bits does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Begin a packet (ignored while busy) |
| tx_pid | input | 8 | Packet identifier to send first |
| tx_len | input | 11 | Payload byte count |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted this cycle when high with in_valid |
| bit_adv | input | 1 | Downstream takes the presented bit |
| out_valid | output | 1 | A bit is presented |
| out_bit | output | 1 | Presented bit |
| out_last | output | 1 | Presented bit is the final check bit |
| tx_busy | output | 1 | Packet in progress |
| len_err | output | 1 | One-cycle flag for a rejected length |
| rx_start | input | 1 | Clear the receive checker |
| rx_valid | input | 1 | Receive bit present |
| rx_bit | input | 1 | Unstuffed receive bit |
| rx_end | input | 1 | End of received packet |
| rx_done | output | 1 | Verdict available |
| rx_crc_ok | output | 1 | Check value matched |

## Verification
The assertions take a few things about the caller for granted. `bit_adv` has meaning only while `out_valid` is high. The payload source never offers more bytes than `tx_len` announced. `rx_end` never shares a cycle with `rx_valid` or `rx_start`. The stimulus offers bytes only while the count of accepted bytes is below the announced length. It drops `rx_valid` before pulsing `rx_end`, and its throttled `bit_adv` patterns simply leave the strobe high or low across the idle cycles, where the transmitter ignores it.

// File: rtl/crcser_pkg.sv
package crcser_pkg;
    localparam logic [15:0] CRC_POLY    = 16'h8005;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'h800D;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PID,
        TX_DATA,
        TX_CRC
    } tx_state_e;
endpackage

// File: rtl/crcser_crc_step.sv
module crcser_crc_step
    import crcser_pkg::*;
(
    input  logic [15:0] crc_i,
    input  logic        bit_i,
    output logic [15:0] crc_o
);
    logic fb;
    always_comb begin
        fb    = crc_i[15] ^ bit_i;
        crc_o = {crc_i[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
endmodule

// File: rtl/crcser_tx.sv
module crcser_tx
    import crcser_pkg::*;
#(
    parameter int MAX_BYTES = 1023,
    parameter int LEFT_W    = $clog2(MAX_BYTES + 1),
    parameter int CNT_W     = LEFT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       pid,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             adv,
    output logic             out_valid,
    output logic             out_bit,
    output logic             out_last,
    output logic             busy,
    output logic             len_err
);
    typedef struct packed {
        tx_state_e         state;
        logic [7:0]        sh;
        logic [15:0]       crc;
        logic [LEFT_W-1:0] left;
        logic [3:0]        bitn;
        logic              full;
        logic              err;
    } tx_regs_t;

    tx_regs_t    tx_d, tx_q;
    logic [15:0] crc_next;

    crcser_crc_step u_step (
        .crc_i (tx_q.crc),
        .bit_i (tx_q.sh[0]),
        .crc_o (crc_next)
    );

    always_comb begin
        tx_d     = tx_q;
        tx_d.err = 1'b0;

        out_valid = (tx_q.state == TX_PID) || (tx_q.state == TX_CRC) ||
                    ((tx_q.state == TX_DATA) && tx_q.full);
        out_bit   = (tx_q.state == TX_CRC) ? ~tx_q.crc[15] : tx_q.sh[0];
        out_last  = (tx_q.state == TX_CRC) && (tx_q.bitn == 4'd15);
        in_ready  = (tx_q.state == TX_DATA) && !tx_q.full;
        busy      = (tx_q.state != TX_IDLE);
        len_err   = tx_q.err;

        unique case (tx_q.state)
            TX_IDLE: begin
                if (start) begin
                    if (byte_count > CNT_W'(MAX_BYTES)) begin
                        tx_d.err = 1'b1;
                    end else begin
                        tx_d.state = TX_PID;
                        tx_d.sh    = pid;
                        tx_d.crc   = CRC_PRESET;
                        tx_d.left  = byte_count[LEFT_W-1:0];
                        tx_d.bitn  = 4'd0;
                        tx_d.full  = 1'b0;
                    end
                end
            end
            TX_PID: begin
                if (adv) begin
                    tx_d.sh   = {1'b0, tx_q.sh[7:1]};
                    tx_d.bitn = tx_q.bitn + 4'd1;
                    if (tx_q.bitn == 4'd7) begin
                        tx_d.bitn  = 4'd0;
                        tx_d.state = (tx_q.left == '0) ? TX_CRC : TX_DATA;
                    end
                end
            end
            TX_DATA: begin
                if (!tx_q.full) begin
                    if (in_valid) begin
                        tx_d.sh   = in_data;
                        tx_d.full = 1'b1;
                    end
                end else if (adv) begin
                    tx_d.crc  = crc_next;
                    tx_d.sh   = {1'b0, tx_q.sh[7:1]};
                    tx_d.bitn = tx_q.bitn + 4'd1;
                    if (tx_q.bitn == 4'd7) begin
                        tx_d.bitn = 4'd0;
                        tx_d.full = 1'b0;
                        tx_d.left = tx_q.left - LEFT_W'(1);
                        if (tx_q.left == LEFT_W'(1)) tx_d.state = TX_CRC;
                    end
                end
            end
            TX_CRC: begin
                if (adv) begin
                    tx_d.crc  = {tx_q.crc[14:0], 1'b0};
                    tx_d.bitn = tx_q.bitn + 4'd1;
                    if (tx_q.bitn == 4'd15) begin
                        tx_d.bitn  = 4'd0;
                        tx_d.state = TX_IDLE;
                    end
                end
            end
            default: tx_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q       <= '0;
            tx_q.state <= TX_IDLE;
            tx_q.crc   <= CRC_PRESET;
        end else begin
            tx_q <= tx_d;
        end
    end

    // R5: a rejected length leaves the transmitter idle and silent
    assert_err_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!busy && !out_valid));

    // R7: a presented bit waits for the strobe
    assert_bit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !adv) |=> (out_valid && $stable(out_bit)));

    // R6: no byte intake while bits are being presented
    assert_ready_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R2: no byte is taken beyond the announced count
    assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (tx_q.left != '0));

    // R8: the final check bit ends the packet
    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && adv) |=> !busy);
endmodule

// File: rtl/crcser_rx.sv
module crcser_rx
    import crcser_pkg::*;
#(
    parameter int MAX_BYTES = 1023,
    parameter int RCNT_W    = $clog2(8 * MAX_BYTES + 25) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic pkt_end,
    output logic done,
    output logic crc_ok
);
    typedef struct packed {
        logic [15:0]       crc;
        logic [RCNT_W-1:0] cnt;
        logic              done;
        logic              ok;
    } rx_regs_t;

    rx_regs_t    rx_d, rx_q;
    logic [15:0] crc_next;

    crcser_crc_step u_step (
        .crc_i (rx_q.crc),
        .bit_i (bit_in),
        .crc_o (crc_next)
    );

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        done      = rx_q.done;
        crc_ok    = rx_q.ok;
        if (start) begin
            rx_d.crc = CRC_PRESET;
            rx_d.cnt = '0;
            rx_d.ok  = 1'b0;
        end else if (bit_valid) begin
            if (rx_q.cnt >= RCNT_W'(8)) rx_d.crc = crc_next;
            if (rx_q.cnt != '1) rx_d.cnt = rx_q.cnt + RCNT_W'(1);
        end else if (pkt_end) begin
            rx_d.done = 1'b1;
            rx_d.ok   = (rx_q.crc == CRC_RESIDUE) &&
                        (rx_q.cnt >= RCNT_W'(24)) && (rx_q.cnt[2:0] == 3'd0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_q.crc <= CRC_PRESET;
        end else begin
            rx_q <= rx_d;
        end
    end

    // R10: the verdict follows the end pulse by one cycle
    assert_done_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pkt_end));

    // R10: the verdict is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pkt_crc_serializer.sv
module pkt_crc_serializer #(
    parameter int MAX_BYTES = 1023,
    localparam int LEFT_W   = $clog2(MAX_BYTES + 1),
    localparam int CNT_W    = LEFT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic [7:0]       tx_pid,
    input  logic [CNT_W-1:0] tx_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             bit_adv,
    output logic             out_valid,
    output logic             out_bit,
    output logic             out_last,
    output logic             tx_busy,
    output logic             len_err,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             rx_end,
    output logic             rx_done,
    output logic             rx_crc_ok
);
    crcser_tx #(
        .MAX_BYTES (MAX_BYTES),
        .LEFT_W    (LEFT_W),
        .CNT_W     (CNT_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_start),
        .pid        (tx_pid),
        .byte_count (tx_len),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .adv        (bit_adv),
        .out_valid  (out_valid),
        .out_bit    (out_bit),
        .out_last   (out_last),
        .busy       (tx_busy),
        .len_err    (len_err)
    );

    crcser_rx #(
        .MAX_BYTES (MAX_BYTES)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rx_start),
        .bit_valid (rx_valid),
        .bit_in    (rx_bit),
        .pkt_end   (rx_end),
        .done      (rx_done),
        .crc_ok    (rx_crc_ok)
    );
endmodule

// File: tb/pkt_crc_serializer_tb_top.sv
module pkt_crc_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_start = 1'b0;
    logic [7:0]  tx_pid = 8'h00;
    logic [10:0] tx_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        bit_adv = 1'b0;
    logic        out_valid, out_bit, out_last, tx_busy, len_err;
    logic        rx_start = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, rx_end = 1'b0;
    logic        rx_done, rx_crc_ok;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pkt_crc_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_pid(tx_pid),
        .tx_len(tx_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .bit_adv(bit_adv), .out_valid(out_valid),
        .out_bit(out_bit), .out_last(out_last), .tx_busy(tx_busy),
        .len_err(len_err), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .rx_end(rx_end), .rx_done(rx_done),
        .rx_crc_ok(rx_crc_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int step, input int i);
        return 8'((seed + step * i) & 255);
    endfunction

    // Reference check value: bit-reversed register form, complemented
    function automatic logic [15:0] ref_crc(input int seed, input int step, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = pat(seed, step, i);
            for (int j = 0; j < 8; j++) begin
                logic fb = c[0] ^ b[j];
                c = c >> 1;
                if (fb) c = c ^ 16'hA001;
            end
        end
        return ~c;
    endfunction

    function automatic logic exp_bit(input logic [7:0] pid, input int n, input int seed,
                                     input int step, input logic [15:0] crc, input int k);
        logic [7:0] b;
        if (k < 8) return pid[k];
        if (k < 8 + 8 * n) begin
            b = pat(seed, step, (k - 8) / 8);
            return b[(k - 8) % 8];
        end
        return crc[k - 8 - 8 * n];
    endfunction

    task automatic send_packet(input string req, input logic [7:0] pid, input int n,
                               input int seed, input int step, input bit throttle,
                               input bit poke);
        int total = 24 + 8 * n;
        int got = 0, idx = 0, cyc = 0, mism = 0, ready_bad = 0, last_bad = 0;
        logic [15:0] crc = ref_crc(seed, step, n);
        @(negedge clk);
        tx_start = 1'b1; tx_pid = pid; tx_len = 11'(n);
        @(negedge clk);
        tx_start = 1'b0;
        while (got < total && cyc < 20000) begin
            in_valid = (idx < n) && (!throttle || (cyc % 3 != 0));
            in_data  = pat(seed, step, idx);
            bit_adv  = !throttle || (cyc % 4 != 1);
            if (poke && cyc == 20) begin
                tx_start = 1'b1; tx_pid = ~pid; tx_len = 11'd3;
            end else begin
                tx_start = 1'b0;
            end
            #1;
            if (in_valid && in_ready) idx++;
            if (out_valid && in_ready) ready_bad++;
            if (out_valid && (got < 8 || got >= 8 + 8 * n) && in_ready) ready_bad++;
            if (out_valid && bit_adv) begin
                if (out_bit !== exp_bit(pid, n, seed, step, crc, got)) mism++;
                if (out_last !== (got == total - 1)) last_bad++;
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        tx_start = 1'b0; in_valid = 1'b0; bit_adv = 1'b0;
        chk(mism == 0, {req, " R1 R2 R3 stream bits"}, mism, 0);
        chk(got == total, {req, " bit count"}, got, total);
        chk(ready_bad == 0, {req, " R6 ready during pid/crc"}, ready_bad, 0);
        chk(last_bad == 0, {req, " R8 out_last position"}, last_bad, 0);
        chk(tx_busy == 1'b0, {req, " R8 idle after last"}, int'(tx_busy), 0);
    endtask

    task automatic rx_feed(input string req, input logic [7:0] pid, input int n,
                           input int seed, input int step, input int flip_k,
                           input bit exp_ok);
        logic [15:0] crc = ref_crc(seed, step, n);
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        for (int k = 0; k < 24 + 8 * n; k++) begin
            rx_valid = 1'b1;
            rx_bit   = exp_bit(pid, n, seed, step, crc, k) ^ (k == flip_k);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_end   = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        chk(rx_done == 1'b1, {req, " R10 done after end"}, int'(rx_done), 1);
        chk(rx_crc_ok == exp_ok, req, int'(rx_crc_ok), int'(exp_ok));
        @(negedge clk);
        chk(rx_done == 1'b0, {req, " R10 done single cycle"}, int'(rx_done), 0);
    endtask

    task automatic test_reset();
        chk(in_ready == 0 && out_valid == 0 && tx_busy == 0 && len_err == 0 && rx_done == 0,
            "reset state R6", int'({in_ready, out_valid, tx_busy, len_err, rx_done}), 0);
    endtask

    task automatic test_empty();
        int zeros = 0;
        send_packet("R4 empty payload", 8'hC3, 0, 0, 1, 1'b0, 1'b0);
        zeros = (ref_crc(0, 1, 0) == 16'h0000) ? 1 : 0;
        chk(zeros == 1, "R4 empty check field zero", zeros, 1);
    endtask

    task automatic test_len_err(input int len);
        int seen = 0;
        @(negedge clk);
        tx_start = 1'b1; tx_len = 11'(len); tx_pid = 8'h4B; bit_adv = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk(len_err == 1'b1 && tx_busy == 1'b0, "R5 len_err raised", int'(len_err), 1);
        for (int i = 0; i < 10; i++) begin
            if (out_valid || tx_busy) seen++;
            @(negedge clk);
            if (i == 0) chk(len_err == 1'b0, "R5 len_err one cycle", int'(len_err), 0);
        end
        chk(seen == 0, "R5 no bits after reject", seen, 0);
        bit_adv = 1'b0;
    endtask

    task automatic test_hold();
        logic held;
        int bad = 0;
        @(negedge clk);
        tx_start = 1'b1; tx_pid = 8'hA5; tx_len = 11'd0;
        @(negedge clk);
        tx_start = 1'b0; bit_adv = 1'b0;
        held = out_bit;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!out_valid || out_bit !== held) bad++;
        end
        chk(bad == 0 && held == 1'b1, "R7 bit held without strobe", bad, 0);
        bit_adv = 1'b1;
        @(negedge clk);
        bit_adv = 1'b0;
        #1;
        chk(out_bit == 1'b0, "R7 one bit per strobe", int'(out_bit), 0);
        bit_adv = 1'b1;
        while (tx_busy) @(negedge clk);
        bit_adv = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_empty();
        send_packet("R2 four bytes", 8'h4B, 4, 0, 1, 1'b0, 1'b0);
        send_packet("R9 throttled with stray start", 8'hC3, 37, 17, 29, 1'b1, 1'b1);
        send_packet("R3 boundary 1023 bytes", 8'h4B, 1023, 5, 3, 1'b0, 1'b0);
        test_len_err(1024);
        test_len_err(2047);
        test_hold();
        rx_feed("R10 good packet", 8'h4B, 4, 0, 1, -1, 1'b1);
        rx_feed("R10 good empty packet", 8'hC3, 0, 0, 1, -1, 1'b1);
        rx_feed("R11 payload bit flip", 8'h4B, 12, 9, 7, 8 + 13, 1'b0);
        rx_feed("R11 check bit flip", 8'h4B, 12, 9, 7, 8 + 96 + 5, 1'b0);
        rx_feed("R11 pid bit flip ignored", 8'h4B, 12, 9, 7, 3, 1'b1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule